// File: doc/BRIEF.md
# Weighted-Bit Pipeline Output Corrector

This block turns the raw one-bit decisions of a fifteen-stage pipelined converter into a twelve-bit output code. The stages resolve one sample over fifteen clocks. Stage k presents its decision k clocks after stage 0 presents its own. A set of per-stage delay lines collects the fifteen bits that belong to one sample into a single aligned vector.

Each stage position has its own weight, held in a small coefficient store. Each weight is a sixteen-bit unsigned value with four fractional bits. The block adds the weights of the set bits, rounds the sum to the nearest integer and clamps it to the twelve-bit range. It then presents the result with a valid flag. A single write port lets the calibration logic replace any weight while conversion keeps running. At reset the store holds the ideal binary weights, so the output is usable before any calibration.

Top module: `wbit_corrector`

## Requirements
- R1: A bit driven on `stage_bits[k]` in cycle t+k is combined with the bit driven on `stage_bits[0]` in cycle t into the same sample.
- R2: Before rounding, a sample's value is the sum of `coef[k]` over every stage k whose bit is 1. Each coefficient is unsigned with 4 fractional bits.
- R3: The sum is rounded to the nearest integer with halves going up: 8 is added to the raw sum and the 4 low bits are then dropped.
- R4: A rounded result above 4095 is output as 4095. The output never wraps.
- R5: The latency is fixed. The stage-0 bit sampled at clock edge e affects `code_out` right after edge e+16.
- R6: `code_valid` is low in reset. It stays low for 18 edges after `rst_n` rises and is high from the 19th edge onward. This count includes the 2-edge reset synchronizer. Once high, it stays high.
- R7: After reset, stage k holds the weight 2^(15-k), which is 2^(11-k) in integer units. Stage 0 alone therefore gives code 2048.
- R8: A write with `coef_we`=1 and `coef_addr`<15 replaces that weight at the sampling edge. A sum formed at that edge uses the old set of weights. Every later sum uses the new set, and no sum mixes the two.
- R9: A write with `coef_addr` of 15 changes no weight.
- R10: While `rst_n` is low, `code_out` is 0 and `code_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stage_bits | input | 15 | Stage decisions; bit k is stage k, staggered by k clocks |
| coef_we | input | 1 | Weight write strobe |
| coef_addr | input | 4 | Stage index of the weight to write |
| coef_wdata | input | 16 | New weight, unsigned, 4 fractional bits |
| code_out | output | 12 | Rounded, clamped output code |
| code_valid | output | 1 | High once the pipeline holds a full sample |

## Verification
Single-stage samples on the reset weights show that each stage reaches its own weight. The stage-0 sample gives 2048. A lone stage-12 bit gives exactly one half, which separates round-half-up from truncation. The all-ones sample on the ideal weights and large random weights drive the sum past 4095 and expose any wrap-around. Random staggered streams mixed with random weight writes show whether alignment, latency and the edge at which a write lands are exactly right, because a bench model that tracks each edge must match on every cycle.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
  localparam int WBC_STAGES = 15;
  localparam int WBC_OUT_W  = 12;
  localparam int WBC_COEF_W = 16;
  localparam int WBC_FRAC_W = 4;

  // Ideal binary weight of stage k, in fixed point with frac_w fractional bits.
  function automatic int unsigned wbc_nominal(int k, int out_w, int frac_w);
    int e;
    e = out_w - 1 - k + frac_w;
    if (e < 0) return 0;
    return 32'd1 << e;
  endfunction
endpackage

// File: rtl/wbc_rst_sync.sv
`timescale 1ns/1ps
module wbc_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [1:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/wbc_deskew.sv
`timescale 1ns/1ps
module wbc_deskew #(
  parameter int N = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] bits_in,
  output logic [N-1:0] aligned_o
);
  // Stage k arrives k clocks late, so it waits N-k registers.
  for (genvar k = 0; k < N; k++) begin : g_bit
    localparam int DEPTH = N - k;
    if (DEPTH == 1) begin : g_one
      logic line_q, line_d;
      always_comb line_d = bits_in[k];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_d;
      end
      assign aligned_o[k] = line_q;
    end else begin : g_line
      logic [DEPTH-1:0] line_q, line_d;
      always_comb line_d = {line_q[DEPTH-2:0], bits_in[k]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
      end
      assign aligned_o[k] = line_q[DEPTH-1];
    end
  end

  // The last stage needs only one register of alignment.
  assert_last_stage_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (aligned_o[N-1] == $past(bits_in[N-1])));
endmodule

// File: rtl/wbc_coef_ram.sv
`timescale 1ns/1ps
module wbc_coef_ram
  import wbc_pkg::*;
#(
  parameter int N      = 15,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 12,
  parameter int FRAC_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [COEF_W-1:0]          wdata,
  output logic [N-1:0][COEF_W-1:0]   coefs_o
);
  typedef logic [N-1:0][COEF_W-1:0] coef_vec_t;

  function automatic coef_vec_t build_nominal();
    coef_vec_t v;
    for (int k = 0; k < N; k++) v[k] = COEF_W'(wbc_nominal(k, OUT_W, FRAC_W));
    return v;
  endfunction

  localparam coef_vec_t NOMINAL = build_nominal();

  coef_vec_t mem_q, mem_d;
  logic      addr_ok, wr_en;

  always_comb begin
    addr_ok = (int'(addr) < N);
    wr_en   = we && addr_ok;
    mem_d   = mem_q;
    if (addr_ok) mem_d[addr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mem_q <= NOMINAL;
    else if (wr_en) mem_q <= mem_d;
  end

  assign coefs_o = mem_q;

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) < N) |=> (mem_q[$past(addr)] == $past(wdata)));

  assert_bad_addr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) >= N) |=> $stable(mem_q));
endmodule

// File: rtl/wbc_accum.sv
`timescale 1ns/1ps
module wbc_accum #(
  parameter int N      = 15,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             aligned_i,
  input  logic [N-1:0][COEF_W-1:0] coefs_i,
  output logic [OUT_W-1:0]         code_o
);
  localparam int SUM_W   = COEF_W + $clog2(N + 1);
  localparam int WHOLE_W = SUM_W - FRAC_W + 1;
  localparam int HALF    = 1 << (FRAC_W - 1);
  localparam int MAXC    = (1 << OUT_W) - 1;
  localparam logic [SUM_W-1:0] SAT_LIM = SUM_W'(((MAXC + 1) << FRAC_W) - HALF);

  logic [SUM_W-1:0]   sum_q, sum_d;
  logic [SUM_W:0]     rnd_w;
  logic [WHOLE_W-1:0] whole;
  logic [OUT_W-1:0]   code_q, code_d;

  // The whole sum is formed in one cycle from one snapshot of the weights.
  always_comb begin
    sum_d = '0;
    for (int k = 0; k < N; k++)
      if (aligned_i[k]) sum_d = sum_d + SUM_W'(coefs_i[k]);
  end

  always_comb begin
    rnd_w = {1'b0, sum_q} + (SUM_W + 1)'(HALF);
    whole = rnd_w[SUM_W:FRAC_W];
    if (whole > WHOLE_W'(MAXC)) code_d = OUT_W'(MAXC);
    else                        code_d = whole[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      code_q <= '0;
    end else begin
      sum_q  <= sum_d;
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

  assert_clamp_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q >= SAT_LIM) |=> (code_o == OUT_W'(MAXC)));
endmodule

// File: rtl/wbit_corrector.sv
`timescale 1ns/1ps
module wbit_corrector
  import wbc_pkg::*;
#(
  parameter int N      = WBC_STAGES,
  parameter int OUT_W  = WBC_OUT_W,
  parameter int COEF_W = WBC_COEF_W,
  parameter int FRAC_W = WBC_FRAC_W,
  localparam int ADDR_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      stage_bits,
  input  logic              coef_we,
  input  logic [ADDR_W-1:0] coef_addr,
  input  logic [COEF_W-1:0] coef_wdata,
  output logic [OUT_W-1:0]  code_out,
  output logic              code_valid
);
  localparam int LAT    = N + 2;
  localparam int FILL_W = $clog2(LAT + 1);

  logic                     rst_n_s;
  logic [N-1:0]             aligned;
  logic [N-1:0][COEF_W-1:0] coefs;
  logic [FILL_W-1:0]        fill_q, fill_d;
  logic                     fill_en;

  wbc_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  wbc_deskew #(.N(N)) i_deskew (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bits_in   (stage_bits),
    .aligned_o (aligned)
  );

  wbc_coef_ram #(
    .N(N), .COEF_W(COEF_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)
  ) i_coef_ram (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we      (coef_we),
    .addr    (coef_addr),
    .wdata   (coef_wdata),
    .coefs_o (coefs)
  );

  wbc_accum #(
    .N(N), .COEF_W(COEF_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)
  ) i_accum (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .aligned_i (aligned),
    .coefs_i   (coefs),
    .code_o    (code_out)
  );

  // Fill counter: saturates once every stage of the pipeline holds real data.
  always_comb begin
    fill_en = (fill_q != FILL_W'(LAT));
    fill_d  = fill_q + FILL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  assign code_valid = (fill_q == FILL_W'(LAT));

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    code_valid |=> code_valid);
endmodule

// File: tb/test_wbit_corrector.sv
`timescale 1ns/1ps
module test_wbit_corrector;
  localparam int CLK_PERIOD = 100;
  localparam int NS = 15;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] stage_bits;
  logic          coef_we;
  logic [3:0]    coef_addr;
  logic [15:0]   coef_wdata;
  logic [11:0]   code_out;
  logic          code_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int edges_after = 0;
  bit done   = 0;

  logic [NS-1:0] hist [32];
  int unsigned   mram [NS];
  int unsigned   m_sum, m_out;

  wbit_corrector i_wbit_corrector (
    .clk(clk), .rst_n(rst_n), .stage_bits(stage_bits),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .code_out(code_out), .code_valid(code_valid)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int unsigned round_clamp(int unsigned s);
    int unsigned r;
    r = (s + 8) >> 4;
    return (r > 4095) ? 4095 : r;
  endfunction

  function automatic int unsigned wsum(logic [NS-1:0] v);
    int unsigned s = 0;
    for (int k = 0; k < NS; k++) if (v[k]) s += mram[k];
    return s;
  endfunction

  // One clock: check the output, drive a new sample column, advance the model by one edge.
  task automatic step(string tag, logic [NS-1:0] samp, bit we, logic [3:0] addr, logic [15:0] data);
    logic [NS-1:0] s15;
    check({tag, " code"}, int'(code_out), int'(m_out));
    check("R6 valid", int'(code_valid), (edges_after >= 19) ? 1 : 0);
    hist[cyc % 32] = samp;
    for (int k = 0; k < NS; k++)
      stage_bits[k] = (cyc - k >= 0) ? hist[(cyc - k) % 32][k] : 1'b0;
    coef_we = we; coef_addr = addr; coef_wdata = data;
    s15 = (cyc - 15 >= 0) ? hist[(cyc - 15) % 32] : '0;
    m_out = round_clamp(m_sum);
    m_sum = wsum(s15);
    if (we && addr < NS) mram[addr] = data;
    cyc++;
    @(posedge clk);
    edges_after++;
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, '0, 1'b0, 4'd0, 16'd0);
  endtask

  initial begin
    int t0;
    t0 = 0;
    while (!done) begin
      @(posedge clk);
      t0++;
      if (t0 > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", t0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) hist[i] = '0;
    for (int k = 0; k < NS; k++) mram[k] = 32'd1 << (15 - k);
    m_sum = 0; m_out = 0;
    rst_n = 0; stage_bits = '0; coef_we = 0; coef_addr = '0; coef_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 code in reset", int'(code_out), 0);
    check("R10 valid in reset", int'(code_valid), 0);
    rst_n = 1;
    edges_after = 0;

    // Fill period: R6 timing of the valid flag.
    idle("R6", 22);

    // Nominal weights and single-stage samples (R7, R3, R1, R5).
    step("R7 stage0", 15'h0001, 0, 0, 0);
    idle("R7 R5", 18);
    step("R3 half", 15'h1000, 0, 0, 0);
    idle("R3", 18);
    step("R3 eighth", 15'h4000, 0, 0, 0);
    idle("R1", 18);
    check("R7 stage0 code", int'(round_clamp(32768)), 2048);

    // All-ones on ideal weights exceeds 4095 (R4).
    step("R4 ones", 15'h7FFF, 0, 0, 0);
    idle("R4", 18);

    // Ignored address (R9), then a weight write (R8) with the same sample before and after.
    step("R9 bad addr", 15'h0001, 1, 4'd15, 16'hFFFF);
    idle("R9", 18);
    step("R8 write", 15'h0001, 1, 4'd0, 16'h0123);
    step("R8 after", 15'h0001, 0, 0, 0);
    idle("R8", 18);

    // Random stream with random writes (R2, R8, R4, R1).
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] d;
      bit w;
      w = ($urandom % 8) == 0;
      d = 16'($urandom);
      if ($urandom % 2) d = d & 16'h0FFF;
      step("R2 R8 random", NS'($urandom), w, 4'($urandom % 16), d);
    end

    // Large weights force clamping (R4).
    for (int k = 0; k < NS; k++) step("R4 load", '0, 1, 4'(k), 16'hF000);
    for (int i = 0; i < 40; i++) step("R4 big", NS'($urandom), 0, 0, 0);
    idle("R4", 18);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule